// File: doc/BRIEF.md
# Synchronous Master Serial Transmitter

This block is the transmit side of a half-duplex synchronous serial port working as clock master. Software writes a word into a holding register. When the internal shift register is free, the word moves into it in a single cycle and is sent least significant bit first on a data line, timed by a shift clock the block makes itself. While that word is being sent, the next word can be written, so consecutive words go out with no gap in the clock. An optional ninth data bit is appended after bit 7.

The shift clock comes from a divider that is held in reset whenever transmit, single-receive and continuous-receive are all disabled. The block arbitrates between transmit and receive requests. A receive request freezes the transmitter and releases the data line. Clearing the transmit enable discards the word in progress and releases both lines. When a single-word receive finishes, its request clears itself and transmission resumes where it stopped. Each pin is modelled as a value plus an output enable.

Top module: `smtx_master_tx`

## Requirements
- R1: After reset, `hold_empty` and `shift_empty` are 1, `rx_single_busy` is 0, and `sck_out`, `sck_oe`, `sdo_out` and `sdo_oe` are all 0.
- R2: The shift clock period is 4*(divisor+1) system cycles. `sck_out` is low between words and only pulses high while a bit is being sent or while receive mode is active.
- R3: Bits are sent least significant first. `sdo_out` changes together with a rising edge of `sck_out` and holds its value through the falling edge that follows.
- R4: A write (`wr_en`=1) makes `hold_empty` 0 on the next cycle. When the shift register is empty, the word moves into it one cycle later, and `hold_empty` returns to 1 at that moment, whether or not anything uses the flag. `hold_empty` goes low only because of a write.
- R5: `shift_empty` is 0 from the transfer until the falling clock edge after the last bit, and 1 at all other times.
- R6: With `nine_bit_en`=1, a ninth bit is sent after bit 7. Its value is `ninth_bit` as sampled in the cycle of the holding-to-shift transfer, not in the cycle of the write.
- R7: A word written while another is being sent goes out directly after it. Rising clock edges stay exactly one period apart across the word boundary.
- R8: With `tx_en`, `rx_cont_en` and the single-receive request all clear, the clock divider is held in reset and `sck_oe` is 0. Setting `tx_en` enables the clock within two cycles. No bit is sent until a word is present, and the first rising edge comes within one clock period of enabling.
- R9: A word written while `tx_en` is 0 is kept, and it is sent once `tx_en` is set.
- R10: Clearing `tx_en` in the middle of a word drops that word, sets `shift_empty` to 1, and sets `sdo_oe` and `sck_oe` to 0. Setting `tx_en` again does not resend the dropped word.
- R11: While a single or continuous receive is requested, `sdo_oe` is 0 and the transmitter holds its state. `sck_oe` equals `int_clk_sel`.
- R12: `rx_single_set` sets `rx_single_busy`, and `rx_word_done` clears it. If `tx_en` is still 1, `sdo_oe` returns to 1 at once and the rest of the frozen word is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable |
| rx_single_set | input | 1 | Pulse that requests a single-word receive |
| rx_word_done | input | 1 | Pulse from the receive path when the single word is complete |
| rx_cont_en | input | 1 | Continuous receive request (level) |
| int_clk_sel | input | 1 | 1 = this block drives the shift clock pin |
| nine_bit_en | input | 1 | Send nine bits per word |
| ninth_bit | input | 1 | Value of the ninth bit |
| divisor | input | DIV_W | Clock divisor; period is 4*(divisor+1) cycles |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Word to write |
| hold_empty | output | 1 | Holding register empty flag |
| shift_empty | output | 1 | Shift register empty status |
| rx_single_busy | output | 1 | Single-word receive request pending |
| sck_out | output | 1 | Shift clock value |
| sck_oe | output | 1 | Shift clock output enable |
| sdo_out | output | 1 | Serial data value |
| sdo_oe | output | 1 | Serial data output enable |

## Verification
The hardest state to reach from the ports is a single-word receive that arrives partway through a word and is then handed back. The request has to land in the quiet part of the clock, away from a rising edge, or the bench cannot tell which bit the freeze caught. The stimulus counts captured rising edges until three bits are out, waits for the clock to fall, raises the request, and checks that the data line is released and that the data value does not move. It then waits for a later falling edge, signals completion, and checks that the five remaining bits follow to make up the original word.

// File: rtl/smtx_pkg.sv
package smtx_pkg;
  typedef enum logic [1:0] {
    MODE_OFF = 2'd0,
    MODE_TX  = 2'd1,
    MODE_RX  = 2'd2
  } port_mode_e;
endpackage

// File: rtl/smtx_baud.sv
module smtx_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             rise_tick,
  output logic             fall_tick
);
  localparam int CW = DIV_W + 1;

  logic [CW-1:0] cnt_q;
  logic          ph_q;
  logic [CW-1:0] half;
  logic          wrap;

  assign half = {div, 1'b1};
  assign wrap = en && (cnt_q >= half);
  assign rise_tick = wrap && !ph_q;
  assign fall_tick = wrap && ph_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      ph_q  <= ~ph_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R8: with the divider disabled no tick may come out of the next cycle
  a_r8_idle_no_tick: assert property (@(posedge clk) disable iff (rst)
    !en |=> !fall_tick);
endmodule

// File: rtl/smtx_shift.sv
module smtx_shift #(
  parameter int SW = 9
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     run,
  input  logic                     load,
  input  logic [SW-1:0]            load_word,
  input  logic [$clog2(SW+1)-1:0]  load_len,
  input  logic                     rise_tick,
  input  logic                     fall_tick,
  output logic                     busy,
  output logic                     launch,
  output logic                     bit_out
);
  localparam int LW = $clog2(SW + 1);

  logic [SW-1:0] sr_q;
  logic [LW-1:0] left_q;
  logic          busy_q;
  logic          bit_q;

  assign launch  = run && busy_q && (left_q != '0) && rise_tick;
  assign busy    = busy_q;
  assign bit_out = bit_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sr_q   <= '0;
      left_q <= '0;
      busy_q <= 1'b0;
      bit_q  <= 1'b0;
    end else if (load) begin
      sr_q   <= load_word;
      left_q <= load_len;
      busy_q <= 1'b1;
    end else if (run) begin
      if (launch) begin
        bit_q  <= sr_q[0];
        sr_q   <= sr_q >> 1;
        left_q <= left_q - 1'b1;
      end else if (fall_tick && busy_q && (left_q == '0)) begin
        busy_q <= 1'b0;
      end
    end
  end

  // R11: a frozen transmitter keeps its word, position and data value
  a_r11_frozen: assert property (@(posedge clk) disable iff (rst)
    (!run && !clr && !load) |=> ($stable(left_q) && $stable(sr_q) && $stable(bit_q)));

  // R4: a new word only enters an empty shift register
  a_r4_load_when_empty: assert property (@(posedge clk) disable iff (rst)
    load |-> !busy_q);

  // R5: the shift register empties only after the last bit or on abort
  a_r5_empty_after_last: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> ($past(clr) || $past(left_q) == '0));
endmodule

// File: rtl/smtx_master_tx.sv
module smtx_master_tx
  import smtx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              rx_single_set,
  input  logic              rx_word_done,
  input  logic              rx_cont_en,
  input  logic              int_clk_sel,
  input  logic              nine_bit_en,
  input  logic              ninth_bit,
  input  logic [DIV_W-1:0]  divisor,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              hold_empty,
  output logic              shift_empty,
  output logic              rx_single_busy,
  output logic              sck_out,
  output logic              sck_oe,
  output logic              sdo_out,
  output logic              sdo_oe
);
  localparam int SW = DATA_W + 1;
  localparam int LW = $clog2(SW + 1);

  logic [DATA_W-1:0] hold_q;
  logic              hold_full_q;
  logic              sreq_q;
  port_mode_e        mode_q;
  logic              sck_q;
  logic              sck_oe_q;
  logic              rx_req;
  logic              baud_en;
  logic              rise_tick;
  logic              fall_tick;
  logic              run;
  logic              xfer;
  logic              sh_busy;
  logic              launch;
  logic              sh_bit;
  logic [SW-1:0]     load_word;
  logic [LW-1:0]     load_len;

  assign rx_req  = sreq_q || rx_cont_en;
  assign baud_en = tx_en || rx_req;
  assign run     = (mode_q == MODE_TX);
  assign xfer    = run && tx_en && !sh_busy && hold_full_q;
  assign load_word = {nine_bit_en & ninth_bit, hold_q};
  assign load_len  = nine_bit_en ? LW'(SW) : LW'(DATA_W);

  smtx_baud #(.DIV_W(DIV_W)) baud_i (
    .clk       (clk),
    .rst       (rst),
    .en        (baud_en),
    .div       (divisor),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  smtx_shift #(.SW(SW)) shift_i (
    .clk       (clk),
    .rst       (rst),
    .clr       (!tx_en),
    .run       (run),
    .load      (xfer),
    .load_word (load_word),
    .load_len  (load_len),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .busy      (sh_busy),
    .launch    (launch),
    .bit_out   (sh_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q      <= '0;
      hold_full_q <= 1'b0;
    end else begin
      if (wr_en) hold_q <= wr_data;
      hold_full_q <= wr_en || (hold_full_q && !xfer);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                sreq_q <= 1'b0;
    else if (rx_word_done)  sreq_q <= 1'b0;
    else if (rx_single_set) sreq_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)         mode_q <= MODE_OFF;
    else if (rx_req) mode_q <= MODE_RX;
    else if (tx_en)  mode_q <= MODE_TX;
    else             mode_q <= MODE_OFF;
  end

  always_ff @(posedge clk) begin
    if (rst || !baud_en)                                  sck_q <= 1'b0;
    else if (fall_tick)                                   sck_q <= 1'b0;
    else if (rise_tick && (launch || mode_q == MODE_RX))  sck_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) sck_oe_q <= 1'b0;
    else     sck_oe_q <= int_clk_sel && baud_en;
  end

  assign hold_empty     = !hold_full_q;
  assign shift_empty    = !sh_busy;
  assign rx_single_busy = sreq_q;
  assign sck_out        = sck_q;
  assign sck_oe         = sck_oe_q;
  assign sdo_out        = sh_bit;
  assign sdo_oe         = run;

  // R4: the shift register fills only from a full holding register
  a_r4_xfer_from_hold: assert property (@(posedge clk) disable iff (rst)
    $rose(sh_busy) |-> $past(hold_full_q));

  // R4: the empty flag drops only because of a write
  a_r4_flag_by_write: assert property (@(posedge clk) disable iff (rst)
    $fell(hold_empty) |-> $past(wr_en));

  // R2: the clock rises only for a launched bit or for receive clocks
  a_r2_sck_rise_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(sck_q) |-> ($past(launch) || $past(mode_q) == MODE_RX));

  // R10: with every enable clear the clock pin is released
  a_r10_released: assert property (@(posedge clk) disable iff (rst)
    (!tx_en && !rx_req) |=> !sck_oe);

  // R12: the single receive request clears on completion
  a_r12_self_clear: assert property (@(posedge clk) disable iff (rst)
    rx_word_done |=> !rx_single_busy);
endmodule

// File: tb/smtx_master_tx_tb.sv
module smtx_master_tx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 8;
  localparam int DIV_W = 8;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic              rst, tx_en, rx_single_set, rx_word_done, rx_cont_en;
  logic              int_clk_sel, nine_bit_en, ninth_bit, wr_en;
  logic [DIV_W-1:0]  divisor;
  logic [DATA_W-1:0] wr_data;
  logic hold_empty, shift_empty, rx_single_busy, sck_out, sck_oe, sdo_out, sdo_oe;

  smtx_master_tx #(.DATA_W(DATA_W), .DIV_W(DIV_W)) dut_i (
    .clk(clk), .rst(rst), .tx_en(tx_en), .rx_single_set(rx_single_set),
    .rx_word_done(rx_word_done), .rx_cont_en(rx_cont_en), .int_clk_sel(int_clk_sel),
    .nine_bit_en(nine_bit_en), .ninth_bit(ninth_bit), .divisor(divisor),
    .wr_en(wr_en), .wr_data(wr_data), .hold_empty(hold_empty),
    .shift_empty(shift_empty), .rx_single_busy(rx_single_busy),
    .sck_out(sck_out), .sck_oe(sck_oe), .sdo_out(sdo_out), .sdo_oe(sdo_oe)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int cap_n = 0;
  int stab_err = 0;
  logic cap_bits [0:63];
  int   rise_t   [0:63];
  logic prev_sck = 1'b0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // capture the data value at each rising clock seen with the data pin driven
  always @(negedge clk) begin
    if (sck_out && !prev_sck && sdo_oe && cap_n < 64) begin
      cap_bits[cap_n] = sdo_out;
      rise_t[cap_n] = cyc;
      cap_n++;
    end
    if (!sck_out && prev_sck && sdo_oe && cap_n > 0 && sdo_out !== cap_bits[cap_n-1])
      stab_err++;
    prev_sck = sck_out;
  end

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int word_at(input int b, input int n);
    int v = 0;
    for (int i = 0; i < n; i++) v |= int'(cap_bits[b+i]) << i;
    return v;
  endfunction

  task automatic gap_check(input string req, input int b, input int n, input int exp);
    int bad = 0;
    for (int i = 1; i < n; i++) if (rise_t[b+i] - rise_t[b+i-1] != exp) bad++;
    check_eq(req, "rise spacing errors", bad, 0);
  endtask

  task automatic write_word(input logic [DATA_W-1:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    int k = 0;
    repeat (2) @(negedge clk);
    while (!(shift_empty && hold_empty) && k < 5000) begin @(negedge clk); k++; end
    check_eq("R5", "word completes", int'(k < 5000), 1);
  endtask

  task automatic wait_caps(input int target);
    int k = 0;
    while (cap_n < target && k < 5000) begin @(negedge clk); k++; end
  endtask

  task automatic t_reset();
    check_eq("R1", "hold_empty", int'(hold_empty), 1);
    check_eq("R1", "shift_empty", int'(shift_empty), 1);
    check_eq("R1", "rx_single_busy", int'(rx_single_busy), 0);
    check_eq("R1", "pins", int'({sck_out, sck_oe, sdo_out, sdo_oe}), 0);
  endtask

  task automatic t_enable_empty();
    int b;
    divisor = 8'd1; int_clk_sel = 1'b1;
    @(negedge clk); tx_en = 1'b1;
    repeat (2) @(negedge clk);
    check_eq("R8", "sck_oe after enable", int'(sck_oe), 1);
    check_eq("R8", "sdo_oe after enable", int'(sdo_oe), 1);
    b = cap_n;
    repeat (40) @(negedge clk);
    check_eq("R8", "no bits without data", cap_n - b, 0);
    check_eq("R2", "clock idles low", int'(sck_out), 0);
  endtask

  task automatic t_single();
    int b = cap_n;
    int s = stab_err;
    write_word(8'hA5);
    check_eq("R4", "flag low after write", int'(hold_empty), 0);
    check_eq("R5", "shift empty before transfer", int'(shift_empty), 1);
    @(negedge clk);
    check_eq("R4", "flag set on transfer", int'(hold_empty), 1);
    check_eq("R5", "shift busy after transfer", int'(shift_empty), 0);
    wait_idle();
    check_eq("R3", "bit count", cap_n - b, 8);
    check_eq("R3", "word lsb first", word_at(b, 8), 32'hA5);
    check_eq("R3", "data stable at fall", stab_err - s, 0);
    gap_check("R2", b, 8, 8);
    b = cap_n;
    repeat (20) @(negedge clk);
    check_eq("R2", "idle low between words", int'(sck_out) + (cap_n - b), 0);
  endtask

  task automatic t_ninth();
    int b = cap_n;
    nine_bit_en = 1'b1; ninth_bit = 1'b1;
    write_word(8'h5A);
    @(negedge clk);
    write_word(8'hC3);
    ninth_bit = 1'b0;
    check_eq("R4", "flag low with word queued", int'(hold_empty), 0);
    wait_idle();
    check_eq("R6", "bit count", cap_n - b, 18);
    check_eq("R6", "first word", word_at(b, 8), 32'h5A);
    check_eq("R6", "first ninth bit", int'(cap_bits[b+8]), 1);
    check_eq("R6", "second word", word_at(b+9, 8), 32'hC3);
    check_eq("R6", "second ninth bit sampled at transfer", int'(cap_bits[b+17]), 0);
    gap_check("R7", b, 18, 8);
    nine_bit_en = 1'b0;
  endtask

  task automatic t_preload();
    int b, t0;
    @(negedge clk); tx_en = 1'b0;
    repeat (3) @(negedge clk);
    b = cap_n;
    write_word(8'h3C);
    repeat (30) @(negedge clk);
    check_eq("R9", "held word not sent", cap_n - b, 0);
    check_eq("R8", "clock released while idle", int'(sck_oe), 0);
    check_eq("R9", "held word kept", int'(hold_empty), 0);
    @(negedge clk); tx_en = 1'b1; t0 = cyc;
    wait_idle();
    check_eq("R9", "held word sent", word_at(b, 8), 32'h3C);
    check_eq("R8", "first edge within a period", int'(rise_t[b] - t0 <= 8 && rise_t[b] > t0), 1);
  endtask

  task automatic t_abort();
    int b = cap_n;
    divisor = 8'd3;
    write_word(8'hF0);
    wait_caps(b + 3);
    @(negedge clk); tx_en = 1'b0;
    repeat (3) @(negedge clk);
    check_eq("R10", "pins released", int'({sck_out, sck_oe, sdo_oe}), 0);
    check_eq("R10", "shift emptied", int'(shift_empty), 1);
    tx_en = 1'b1;
    repeat (100) @(negedge clk);
    check_eq("R10", "dropped word not resent", cap_n - b, 3);
  endtask

  task automatic t_rx_single();
    int b = cap_n;
    int n0;
    logic d0;
    write_word(8'h96);
    wait_caps(b + 3);
    while (sck_out) @(negedge clk);
    rx_single_set = 1'b1;
    @(negedge clk); rx_single_set = 1'b0;
    repeat (2) @(negedge clk);
    check_eq("R11", "data released", int'(sdo_oe), 0);
    check_eq("R11", "clock driven", int'(sck_oe), 1);
    check_eq("R11", "word kept", int'(shift_empty), 0);
    check_eq("R12", "request pending", int'(rx_single_busy), 1);
    n0 = cap_n; d0 = sdo_out;
    repeat (48) @(negedge clk);
    check_eq("R11", "data frozen", int'(sdo_out == d0 && cap_n == n0), 1);
    while (!sck_out) @(negedge clk);
    while (sck_out) @(negedge clk);
    rx_word_done = 1'b1;
    @(negedge clk); rx_word_done = 1'b0;
    repeat (2) @(negedge clk);
    check_eq("R12", "request cleared", int'(rx_single_busy), 0);
    check_eq("R12", "data driven again", int'(sdo_oe), 1);
    wait_idle();
    check_eq("R12", "word resumed", word_at(b, 8), 32'h96);
    check_eq("R12", "bit count", cap_n - b, 8);
  endtask

  task automatic t_rx_cont();
    @(negedge clk); int_clk_sel = 1'b0; rx_cont_en = 1'b1;
    repeat (3) @(negedge clk);
    check_eq("R11", "external clock not driven", int'(sck_oe), 0);
    check_eq("R11", "data released in continuous", int'(sdo_oe), 0);
    rx_cont_en = 1'b0; int_clk_sel = 1'b1;
    repeat (3) @(negedge clk);
    check_eq("R11", "transmit mode back", int'(sdo_oe && sck_oe), 1);
  endtask

  initial begin
    rst = 1'b1; tx_en = 1'b0; rx_single_set = 1'b0; rx_word_done = 1'b0;
    rx_cont_en = 1'b0; int_clk_sel = 1'b0; nine_bit_en = 1'b0; ninth_bit = 1'b0;
    divisor = '0; wr_en = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_enable_empty();
    t_single();
    t_ninth();
    t_preload();
    t_abort();
    t_rx_single();
    t_rx_cont();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule